// File: doc/BRIEF.md
# Multi-Mode Programmable Counter Channel

This block is a single down-counting timer channel. It advances only on cycles where the count-enable tick input is high, so one fast clock can drive slow timing. A load strobe captures a reload value and a three-bit mode selection. A gate input either suspends counting or restarts it, depending on the mode. One counter drives six output waveforms:

- a terminal-count level,
- a gate-triggered one-shot,
- a periodic rate pulse,
- a square wave,
- two kinds of single-tick strobe.

The current count can be read at any time. A reload value of zero stands for a full count of 2^WIDTH. The channel is meant to be replicated inside a larger timer subsystem. Register access and decimal counting sit outside this block.

Top module: `pcc_channel`

## Requirements
- R1: After reset, `cnt_out` is 0 and `wave_out` is 0. Ticks and gate edges have no effect until the first load.
- R2: A high `load` captures `reload_val` and `mode_sel` at the clock edge. From the next cycle, `cnt_out` equals the captured value and the sequence restarts. A load takes priority over a tick or a gate edge in the same cycle.
- R3: A reload value of 0 acts as a count of 2^WIDTH. The terminal event comes only after 2^WIDTH counted ticks.
- R4: Mode 0 (terminal level): `wave_out` is 0 after a load and rises on the N-th counted tick. It then stays 1 until the next load.
- R5: Mode 1 (one-shot): `wave_out` is 0 while the N counted ticks run after a load or trigger. It goes to 1 on the N-th tick and then holds 1.
- R6: Mode 2 (rate): `wave_out` is 1 for exactly one tick interval after every N-th counted tick. There is no pulse at the start. The count reloads to N at each pulse.
- R7: Mode 3 (square): with period N, `wave_out` is 1 for (N+1)/2 counted ticks (integer division) and 0 for the rest. It is 1 right after a load, and the count reloads to N every period.
- R8: Modes 4 and 5 (strobes): `wave_out` is 1 for one tick interval after the N-th counted tick. It then stays 0, even when the count wraps, until the next load or trigger.
- R9: In modes 0, 2, 3 and 4, a low `gate` suspends counting and the count is kept. In modes 1 and 5, the gate level does not affect counting.
- R10: In modes 1, 2, 3 and 5, a rising edge on `gate` reloads the count from the stored reload value and restarts the waveform in the same clock edge. In modes 0 and 4, a rising edge does nothing.
- R11: `mode_sel` value 6 behaves as mode 2, and value 7 behaves as mode 3.
- R12: In modes 0, 1, 4 and 5, the count keeps decrementing after the terminal event and wraps modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable tick, one count per high cycle |
| load | input | 1 | Capture reload value and mode |
| reload_val | input | WIDTH | Reload value, 0 means 2^WIDTH |
| mode_sel | input | 3 | Operating mode |
| gate | input | 1 | Gate level / retrigger input |
| cnt_out | output | WIDTH | Current count |
| wave_out | output | 1 | Mode-dependent output waveform |

## Verification
The bench builds the channel with WIDTH set to 8. With that width, the full 2^WIDTH count behind a zero reload, and a complete wrap of the count after a strobe, each take only a few hundred ticks. Every waveform boundary for small periods (odd and even square-wave periods, rate pulses, strobe and one-shot edges) is checked at exact tick offsets. Directed sequences cover gate suspension, retrigger edges and load priority.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        MD_TERM     = 3'd0,
        MD_ONESHOT  = 3'd1,
        MD_RATE     = 3'd2,
        MD_SQUARE   = 3'd3,
        MD_SWSTROBE = 3'd4,
        MD_HWSTROBE = 3'd5
    } pcc_mode_e;

    typedef struct packed {
        logic level_en;   // gate low suspends counting
        logic retrig;     // gate rising edge restarts
        logic periodic;   // count reloads at terminal
        logic init_out;   // output level after (re)start
    } pcc_attr_t;

endpackage

// File: rtl/pcc_mode_norm.sv
module pcc_mode_norm
    import pcc_pkg::*;
(
    input  logic [2:0] raw,
    output pcc_mode_e  mode
);
    always_comb begin
        unique case (raw)
            3'd0:    mode = MD_TERM;
            3'd1:    mode = MD_ONESHOT;
            3'd2:    mode = MD_RATE;
            3'd3:    mode = MD_SQUARE;
            3'd4:    mode = MD_SWSTROBE;
            3'd5:    mode = MD_HWSTROBE;
            3'd6:    mode = MD_RATE;     // alias, R11
            default: mode = MD_SQUARE;   // 7 aliases square, R11
        endcase
    end
endmodule

// File: rtl/pcc_mode_attr.sv
module pcc_mode_attr
    import pcc_pkg::*;
(
    input  pcc_mode_e mode,
    output pcc_attr_t attr
);
    always_comb begin
        attr = '0;
        unique case (mode)
            MD_TERM:     attr = '{level_en: 1'b1, retrig: 1'b0, periodic: 1'b0, init_out: 1'b0};
            MD_ONESHOT:  attr = '{level_en: 1'b0, retrig: 1'b1, periodic: 1'b0, init_out: 1'b0};
            MD_RATE:     attr = '{level_en: 1'b1, retrig: 1'b1, periodic: 1'b1, init_out: 1'b0};
            MD_SQUARE:   attr = '{level_en: 1'b1, retrig: 1'b1, periodic: 1'b1, init_out: 1'b1};
            MD_SWSTROBE: attr = '{level_en: 1'b1, retrig: 1'b0, periodic: 1'b0, init_out: 1'b0};
            MD_HWSTROBE: attr = '{level_en: 1'b0, retrig: 1'b1, periodic: 1'b0, init_out: 1'b0};
            default:     attr = '0;
        endcase
    end
endmodule

// File: rtl/pcc_gate_edge.sv
module pcc_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d = gate;
        rise   = gate & ~gate_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/pcc_count_step.sv
module pcc_count_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] reload,
    input  logic             periodic,
    output logic [WIDTH-1:0] next_count,
    output logic             hit
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        hit = (count == ONE);
        if (periodic && hit) next_count = reload;
        else                 next_count = count - ONE;
    end
endmodule

// File: rtl/pcc_square_phase.sv
module pcc_square_phase #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] reload,
    output logic             high
);
    localparam int XW = WIDTH + 1;

    logic [XW-1:0] cnt_full;
    logic [XW-1:0] per_full;

    always_comb begin
        // a stored zero stands for the full 2^WIDTH value
        cnt_full = {(count == '0), count};
        per_full = {(reload == '0), reload};
        high     = (cnt_full > (per_full >> 1));
    end
endmodule

// File: rtl/pcc_channel.sv
module pcc_channel
    import pcc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [WIDTH-1:0] reload_val,
    input  logic [2:0]       mode_sel,
    input  logic             gate,
    output logic [WIDTH-1:0] cnt_out,
    output logic             wave_out
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic [WIDTH-1:0] reload;
        pcc_mode_e        mode;
        logic             live;
        logic             done;
        logic             out;
    } chan_st_t;

    chan_st_t st_d, st_q;

    pcc_mode_e        ld_mode;
    pcc_attr_t        cur_attr;
    logic             gate_rise;
    logic [WIDTH-1:0] step_next;
    logic             step_hit;
    logic             sq_high;
    logic             cnt_en;

    pcc_mode_norm u_norm (
        .raw  (mode_sel),
        .mode (ld_mode)
    );

    pcc_mode_attr u_attr (
        .mode (st_q.mode),
        .attr (cur_attr)
    );

    pcc_gate_edge u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (gate_rise)
    );

    pcc_count_step #(.WIDTH(WIDTH)) u_step (
        .count      (st_q.count),
        .reload     (st_q.reload),
        .periodic   (cur_attr.periodic),
        .next_count (step_next),
        .hit        (step_hit)
    );

    pcc_square_phase #(.WIDTH(WIDTH)) u_sq (
        .count  (step_next),
        .reload (st_q.reload),
        .high   (sq_high)
    );

    always_comb begin
        st_d   = st_q;
        cnt_en = st_q.live && tick && (gate || !cur_attr.level_en);
        if (load) begin
            st_d.count  = reload_val;
            st_d.reload = reload_val;
            st_d.mode   = ld_mode;
            st_d.live   = 1'b1;
            st_d.done   = 1'b0;
            st_d.out    = (ld_mode == MD_SQUARE);
        end else if (st_q.live && gate_rise && cur_attr.retrig) begin
            st_d.count = st_q.reload;
            st_d.done  = 1'b0;
            st_d.out   = cur_attr.init_out;
        end else if (cnt_en) begin
            st_d.count = step_next;
            unique case (st_q.mode)
                MD_TERM, MD_ONESHOT: begin
                    if (step_hit && !st_q.done) begin
                        st_d.out  = 1'b1;
                        st_d.done = 1'b1;
                    end
                end
                MD_RATE:   st_d.out = step_hit;
                MD_SQUARE: st_d.out = sq_high;
                MD_SWSTROBE, MD_HWSTROBE: begin
                    st_d.out = step_hit && !st_q.done;
                    if (step_hit) st_d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_out  = st_q.count;
    assign wave_out = st_q.out;

endmodule

// File: rtl/pcc_channel_checker.sv
module pcc_channel_checker
    import pcc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             gate,
    input  logic [WIDTH-1:0] reload_val,
    input  logic [WIDTH-1:0] cnt_out,
    input  logic             wave_out,
    input  logic             gate_rise,
    input  logic             live_q,
    input  pcc_mode_e        mode_q,
    input  logic [WIDTH-1:0] reload_q
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (cnt_out == '0 && !wave_out));

    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_out == $past(reload_val)));

    p_term_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TERM && wave_out && !load) |=> wave_out);

    p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_ONESHOT && wave_out && !load && !gate_rise) |=> wave_out);

    p_strobe_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_HWSTROBE && wave_out && tick && !load && !gate_rise) |=> !wave_out);

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick && !gate_rise) |=> $stable(cnt_out));

    p_suspend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !gate_rise && !gate &&
         (mode_q == MD_TERM || mode_q == MD_RATE ||
          mode_q == MD_SQUARE || mode_q == MD_SWSTROBE)) |=> $stable(cnt_out));

    p_retrig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && gate_rise && !load &&
         (mode_q == MD_ONESHOT || mode_q == MD_RATE ||
          mode_q == MD_SQUARE || mode_q == MD_HWSTROBE)) |=> (cnt_out == $past(reload_q)));
endmodule

bind pcc_channel pcc_channel_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (load),
    .gate       (gate),
    .reload_val (reload_val),
    .cnt_out    (cnt_out),
    .wave_out   (wave_out),
    .gate_rise  (gate_rise),
    .live_q     (st_q.live),
    .mode_q     (st_q.mode),
    .reload_q   (st_q.reload)
);

// File: tb/pcc_channel_tb.sv
module pcc_channel_tb;
    localparam int W  = 8;
    localparam int NV = 34;

    // {req[3:0], mode[2:0], reload[7:0], ticks[15:0], exp_cnt[7:0], exp_out}
    localparam logic [39:0] VEC [NV] = '{
        {4'd4,  3'd0, 8'd5, 16'd0,   8'd5,   1'b0},  // R4
        {4'd4,  3'd0, 8'd5, 16'd4,   8'd1,   1'b0},  // R4
        {4'd4,  3'd0, 8'd5, 16'd5,   8'd0,   1'b1},  // R4
        {4'd12, 3'd0, 8'd5, 16'd7,   8'd254, 1'b1},  // R12
        {4'd3,  3'd0, 8'd0, 16'd255, 8'd1,   1'b0},  // R3
        {4'd3,  3'd0, 8'd0, 16'd256, 8'd0,   1'b1},  // R3
        {4'd5,  3'd1, 8'd3, 16'd2,   8'd1,   1'b0},  // R5
        {4'd5,  3'd1, 8'd3, 16'd3,   8'd0,   1'b1},  // R5
        {4'd12, 3'd1, 8'd3, 16'd5,   8'd254, 1'b1},  // R12
        {4'd6,  3'd2, 8'd4, 16'd0,   8'd4,   1'b0},  // R6
        {4'd6,  3'd2, 8'd4, 16'd3,   8'd1,   1'b0},  // R6
        {4'd6,  3'd2, 8'd4, 16'd4,   8'd4,   1'b1},  // R6
        {4'd6,  3'd2, 8'd4, 16'd5,   8'd3,   1'b0},  // R6
        {4'd6,  3'd2, 8'd4, 16'd8,   8'd4,   1'b1},  // R6
        {4'd3,  3'd2, 8'd0, 16'd255, 8'd1,   1'b0},  // R3
        {4'd3,  3'd2, 8'd0, 16'd256, 8'd0,   1'b1},  // R3
        {4'd7,  3'd3, 8'd5, 16'd0,   8'd5,   1'b1},  // R7
        {4'd7,  3'd3, 8'd5, 16'd2,   8'd3,   1'b1},  // R7
        {4'd7,  3'd3, 8'd5, 16'd3,   8'd2,   1'b0},  // R7
        {4'd7,  3'd3, 8'd5, 16'd4,   8'd1,   1'b0},  // R7
        {4'd7,  3'd3, 8'd5, 16'd5,   8'd5,   1'b1},  // R7
        {4'd7,  3'd3, 8'd4, 16'd1,   8'd3,   1'b1},  // R7
        {4'd7,  3'd3, 8'd4, 16'd2,   8'd2,   1'b0},  // R7
        {4'd7,  3'd3, 8'd4, 16'd4,   8'd4,   1'b1},  // R7
        {4'd8,  3'd4, 8'd3, 16'd2,   8'd1,   1'b0},  // R8
        {4'd8,  3'd4, 8'd3, 16'd3,   8'd0,   1'b1},  // R8
        {4'd8,  3'd4, 8'd3, 16'd4,   8'd255, 1'b0},  // R8
        {4'd12, 3'd4, 8'd3, 16'd259, 8'd0,   1'b0},  // R12
        {4'd8,  3'd5, 8'd2, 16'd2,   8'd0,   1'b1},  // R8
        {4'd8,  3'd5, 8'd2, 16'd3,   8'd255, 1'b0},  // R8
        {4'd11, 3'd6, 8'd4, 16'd4,   8'd4,   1'b1},  // R11
        {4'd11, 3'd6, 8'd4, 16'd3,   8'd1,   1'b0},  // R11
        {4'd11, 3'd7, 8'd5, 16'd3,   8'd2,   1'b0},  // R11
        {4'd11, 3'd7, 8'd5, 16'd2,   8'd3,   1'b1}   // R11
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic [2:0]   mode_sel = 3'd0;
    logic         gate = 1'b1;
    logic [W-1:0] cnt_out;
    logic         wave_out;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pcc_channel #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .reload_val (reload_val),
        .mode_sel   (mode_sel),
        .gate       (gate),
        .cnt_out    (cnt_out),
        .wave_out   (wave_out)
    );

    task automatic check(input int req, input logic [W-1:0] exp_c, input logic exp_o);
        n_run++;
        if (cnt_out !== exp_c || wave_out !== exp_o) begin
            n_fail++;
            $display("FAIL R%0d: cnt=%0d out=%0b expected cnt=%0d out=%0b",
                     req, cnt_out, wave_out, exp_c, exp_o);
        end
    endtask

    task automatic do_load(input logic [2:0] m, input logic [W-1:0] v);
        @(negedge clk);
        load = 1'b1; mode_sel = m; reload_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic set_gate(input logic g);
        gate = g;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 8'd0, 1'b0);            // R1 reset state
        run_ticks(5);
        set_gate(1'b0); set_gate(1'b1);
        check(1, 8'd0, 1'b0);            // R1 ignored before load

        for (int i = 0; i < NV; i++) begin
            gate = 1'b1;
            do_load(VEC[i][35:33], VEC[i][32:25]);
            run_ticks(int'(VEC[i][24:9]));
            check(int'(VEC[i][39:36]), VEC[i][8:1], VEC[i][0]);
        end

        // R9: gate low suspends mode 0, count kept
        gate = 1'b1;
        do_load(3'd0, 8'd5);
        run_ticks(2);
        set_gate(1'b0);
        run_ticks(3);
        check(9, 8'd3, 1'b0);
        // R10: rising gate in mode 0 does not restart
        set_gate(1'b1);
        check(10, 8'd3, 1'b0);
        run_ticks(3);
        check(4, 8'd0, 1'b1);

        // R9: gate low in mode 4 suspends
        do_load(3'd4, 8'd3);
        set_gate(1'b0);
        run_ticks(5);
        check(9, 8'd3, 1'b0);
        gate = 1'b1;

        // R9: mode 1 counts with gate low
        set_gate(1'b0);
        do_load(3'd1, 8'd3);
        run_ticks(3);
        check(9, 8'd0, 1'b1);
        // R10: rising gate retriggers one-shot
        set_gate(1'b1);
        check(10, 8'd3, 1'b0);
        run_ticks(3);
        check(5, 8'd0, 1'b1);

        // R10: retrigger mode 2 mid period
        do_load(3'd2, 8'd4);
        run_ticks(2);
        check(6, 8'd2, 1'b0);
        set_gate(1'b0);
        set_gate(1'b1);
        check(10, 8'd4, 1'b0);

        // R10: retrigger hardware strobe after it fired
        do_load(3'd5, 8'd2);
        run_ticks(3);
        check(8, 8'd255, 1'b0);
        set_gate(1'b0);
        set_gate(1'b1);
        check(10, 8'd2, 1'b0);
        run_ticks(2);
        check(8, 8'd0, 1'b1);

        // R2: load dominates a same-cycle tick, restarts square wave
        do_load(3'd2, 8'd4);
        run_ticks(1);
        @(negedge clk);
        load = 1'b1; tick = 1'b1; mode_sel = 3'd3; reload_val = 8'd9;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
        check(2, 8'd9, 1'b1);
        run_ticks(5);
        check(7, 8'd4, 1'b0);

        // R1: reset mid-run returns to idle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_ticks(2);
        check(1, 8'd0, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule